// File: doc/BRIEF.md
# Parallel-to-Serial Interrupt Encoder

This block watches eleven parallel ISA interrupt request inputs and reports their levels to a host over one shared open-drain serial interrupt line. It runs on the PCI clock and is reset by the active-low PCI reset. The only inputs it accepts are the lines for interrupt numbers 3, 4, 5, 6, 7, 9, 10, 11, 12, 14 and 15. There is no input for 0, 1, 2, 8 or 13.

The host opens a frame by holding the line low for at least four clocks. The block then counts sixteen slots, one for each interrupt number from 0 to 15. Each slot lasts three clocks: a sample phase, a recovery phase and a turnaround phase. In the sample phase of an accepted and enabled interrupt, the block pulls the line low when that input is low. Otherwise it leaves the line released, and the external pull-up makes it read high. The block never drives the line high.

Two mask bytes disable interrupts one by one, with 1 meaning disabled. In quiet mode the block can ask for a frame. When an enabled input changes, it pulls the line low for one clock. In continuous mode it only waits for host start pulses. The line is a plain level and the configuration port is a simple write/read port, so there is no back-pressure at any interface.

Top module: `pirq_serializer`

## Requirements
- R1: After reset, both mask bytes read 00h and `sirq_oe` is 0.
- R2: Mask byte 0 (`cfg_sel`=0) holds bits 0..7 for interrupts 3, 4, 5, 6, 7, 9, 10, 11, in that bit order. A bit at 1 disables that interrupt. The byte reads back as it was written.
- R3: Mask byte 1 (`cfg_sel`=1) holds bit 0 for interrupt 12, bit 1 for interrupt 14 and bit 2 for interrupt 15. Bits 7:3 read as zero whatever is written.
- R4: Suppose the line has been seen low for at least 4 consecutive rising edges and is then first seen high at a rising edge. The sample phase of slot 0 begins at the next rising edge.
- R5: A low pulse seen on fewer than 4 consecutive rising edges starts no frame.
- R6: A frame has 16 slots, numbered by interrupt number 0..15, and each slot is 3 clocks long. `sirq_oe` is 0 in every recovery and turnaround phase.
- R7: In the sample phase of an accepted, enabled interrupt, `sirq_oe` is 1 when that input is low and 0 when it is high.
- R8: In a disabled interrupt's slot, and in slots 0, 1, 2, 8 and 13, `sirq_oe` stays 0.
- R9: In quiet mode (`quiet_mode`=1), a change on an enabled input while the block is idle drives `sirq_oe` to 1 for exactly one clock. This happens two clocks after the rising edge that first registers the new input value.
- R10: A change on a disabled input, or any change in continuous mode (`quiet_mode`=0), produces no request pulse.
- R11: After slot 15 the block returns to idle. A stop pulse of 2 clocks that follows starts no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| irq_in | input | 11 | Parallel inputs; bit k is the k-th accepted interrupt in ascending number order |
| quiet_mode | input | 1 | 1 = block may request frames, 0 = host starts every frame |
| sirq_in | input | 1 | Sampled level of the serial interrupt line |
| sirq_oe | output | 1 | 1 = pull the serial line low, 0 = release it |
| cfg_wr | input | 1 | Write strobe for the selected mask byte |
| cfg_sel | input | 1 | Mask byte select (0 or 1) |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of the selected mask byte |

## Verification
Some rules are checked by assertions on every cycle. The block drives the line only in a sample phase or as a quiet-mode request. A request pulse lasts a single clock and is issued only while idle. Slots advance in strict order and the frame closes after slot 15. Mask byte 1 keeps exactly its three defined bits. No request is pending in continuous mode. Other behaviour can only be shown by the bench's scenarios, because it depends on how the host drives the line and on chosen input patterns. That covers the exact cycle at which slot 0 begins, the slot-to-interrupt mapping, the low-level encoding under varied masks, the rejection of short and stop pulses, and the two-clock latency of the quiet-mode request.

// File: rtl/pirq_ser_pkg.sv
package pirq_ser_pkg;

  localparam int NUM_SLOTS = 16;
  localparam logic [NUM_SLOTS-1:0] ACCEPT_MAP = 16'hDEF8;
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  function automatic int count_set(input logic [NUM_SLOTS-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < NUM_SLOTS; i++) c += int'(v[i]);
    return c;
  endfunction

  // input index of an accepted slot = number of accepted slots below it
  function automatic int slot_to_idx(input int slot);
    int c;
    c = 0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (i < slot && ACCEPT_MAP[i]) c++;
    return c;
  endfunction

  localparam int NUM_IN = count_set(ACCEPT_MAP);

  typedef enum logic {ST_IDLE, ST_FRAME} fr_state_t;
  typedef enum logic [1:0] {PH_SAMPLE = 2'd0, PH_RECOV = 2'd1, PH_TURN = 2'd2} phase_t;

endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs #(
  parameter int NUM_IN = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NUM_IN-1:0] dis
);
  localparam int HI_W = NUM_IN - 8;

  logic [7:0]      mask_lo;
  logic [HI_W-1:0] mask_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_lo <= '0;
      mask_hi <= '0;
    end else if (wr) begin
      if (sel) mask_hi <= wdata[HI_W-1:0];
      else     mask_lo <= wdata;
    end
  end

  assign dis   = {mask_hi, mask_lo};
  assign rdata = sel ? {{(8-HI_W){1'b0}}, mask_hi} : mask_lo;

  AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel) |=> (mask_hi == $past(wdata[HI_W-1:0]))); // R3

endmodule

// File: rtl/pirq_chg_detect.sv
module pirq_chg_detect #(
  parameter int NUM_IN = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic [NUM_IN-1:0] dis,
  input  logic              quiet,
  input  logic              issue,
  output logic [NUM_IN-1:0] irq_s,
  output logic              pend
);
  logic [NUM_IN-1:0] irq_p;
  logic              chg;

  assign chg = quiet && (|((irq_s ^ irq_p) & ~dis));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_s <= '0;
      irq_p <= '0;
      pend  <= 1'b0;
    end else begin
      irq_s <= irq_in;
      irq_p <= irq_s;
      pend  <= quiet && ((pend && !issue) || chg);
    end
  end

  AST_QUIET_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !quiet |=> !pend); // R10

endmodule

// File: rtl/pirq_frame_fsm.sv
module pirq_frame_fsm
  import pirq_ser_pkg::*;
#(
  parameter int START_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_q,
  input  logic              pend,
  output fr_state_t         st,
  output logic [SLOT_W-1:0] slot,
  output phase_t            ph,
  output logic              issue,
  output logic              req_q
);
  localparam int CNT_W = $clog2(START_MIN + 1);
  localparam logic [CNT_W-1:0]  CNT_SAT = CNT_W'(START_MIN);
  localparam logic [SLOT_W-1:0] LAST    = SLOT_W'(NUM_SLOTS - 1);

  logic [CNT_W-1:0] low_cnt;

  assign issue = (st == ST_IDLE) && line_q && (low_cnt == '0) && pend && !req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      slot    <= '0;
      ph      <= PH_SAMPLE;
      low_cnt <= '0;
      req_q   <= 1'b0;
    end else begin
      req_q <= issue;
      case (st)
        ST_IDLE: begin
          if (!line_q) begin
            if (low_cnt != CNT_SAT) low_cnt <= low_cnt + 1'b1;
          end else begin
            low_cnt <= '0;
            if (low_cnt == CNT_SAT) begin
              st   <= ST_FRAME;
              slot <= '0;
              ph   <= PH_SAMPLE;
            end
          end
        end
        default: begin
          low_cnt <= '0;
          case (ph)
            PH_SAMPLE: ph <= PH_RECOV;
            PH_RECOV:  ph <= PH_TURN;
            default: begin
              ph <= PH_SAMPLE;
              if (slot == LAST) begin
                st   <= ST_IDLE;
                slot <= '0;
              end else begin
                slot <= slot + 1'b1;
              end
            end
          endcase
        end
      endcase
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |=> !req_q); // R9
  AST_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> (st == ST_IDLE)); // R9
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FRAME && ph == PH_TURN && slot != LAST) |=>
      (st == ST_FRAME && ph == PH_SAMPLE && slot == SLOT_W'($past(slot) + 1'b1))); // R6
  AST_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FRAME && ph == PH_TURN && slot == LAST) |=> (st == ST_IDLE)); // R11

endmodule

// File: rtl/pirq_serializer.sv
module pirq_serializer
  import pirq_ser_pkg::*;
#(
  parameter int START_MIN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] irq_in,
  input  logic              quiet_mode,
  input  logic              sirq_in,
  output logic              sirq_oe,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata
);
  logic [NUM_IN-1:0]    dis;
  logic [NUM_IN-1:0]    irq_s;
  logic                 pend;
  logic                 issue;
  logic                 req_q;
  logic                 line_q;
  fr_state_t            st;
  logic [SLOT_W-1:0]    slot;
  phase_t               ph;
  logic [NUM_SLOTS-1:0] slot_drive;
  logic                 frame_drive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b1;
    else        line_q <= sirq_in;
  end

  pirq_cfg_regs #(.NUM_IN(NUM_IN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .dis(dis)
  );

  pirq_chg_detect #(.NUM_IN(NUM_IN)) u_chg (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .dis(dis),
    .quiet(quiet_mode), .issue(issue), .irq_s(irq_s), .pend(pend)
  );

  pirq_frame_fsm #(.START_MIN(START_MIN)) u_fsm (
    .clk(clk), .rst_n(rst_n), .line_q(line_q), .pend(pend),
    .st(st), .slot(slot), .ph(ph), .issue(issue), .req_q(req_q)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    if (ACCEPT_MAP[s]) begin : g_acc
      localparam int IDX = slot_to_idx(s);
      assign slot_drive[s] = ~irq_s[IDX] & ~dis[IDX];
    end else begin : g_rej
      assign slot_drive[s] = 1'b0;
    end
  end

  assign frame_drive = (st == ST_FRAME) && (ph == PH_SAMPLE) && slot_drive[slot];
  assign sirq_oe     = frame_drive | req_q;

  AST_OE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    sirq_oe |-> (st == ST_IDLE || ph == PH_SAMPLE)); // R6
  AST_UNACCEPTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FRAME && !ACCEPT_MAP[slot]) |-> !sirq_oe); // R8

endmodule

// File: tb/pirq_serializer_test.sv
module pirq_serializer_test;
  import pirq_ser_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_IN-1:0] irq_in = '0;
  logic              quiet_mode = 1'b0;
  logic              host_low = 1'b0;
  logic              sirq_in;
  logic              sirq_oe;
  logic              cfg_wr = 1'b0;
  logic              cfg_sel = 1'b0;
  logic [7:0]        cfg_wdata = '0;
  logic [7:0]        cfg_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sirq_in = ~(sirq_oe | host_low);

  pirq_serializer uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .quiet_mode(quiet_mode),
    .sirq_in(sirq_in), .sirq_oe(sirq_oe), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  localparam int IRQ_NUM [11] = '{3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};

  // {irq_in, mask byte 0, mask byte 1[2:0]}
  localparam int NVEC = 6;
  localparam logic [21:0] VEC [NVEC] = '{
    {11'h000, 8'h00, 3'h0},
    {11'h7FF, 8'h00, 3'h0},
    {11'h000, 8'hFF, 3'h7},
    {11'h555, 8'h0F, 3'h2},
    {11'h2AA, 8'hA0, 3'h5},
    {11'h001, 8'h80, 3'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_mask(input logic [10:0] irq, input logic [7:0] m0,
                                           input logic [2:0] m1);
    logic [15:0] m;
    logic [10:0] d;
    m = '0;
    d = {m1, m0};
    for (int k = 0; k < 11; k++)
      if (!d[k] && !irq[k]) m[IRQ_NUM[k]] = 1'b1;
    return m;
  endfunction

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic sel, output logic [7:0] d);
    @(negedge clk);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic run_frame(output logic [15:0] seen, output bit rel_ok);
    rel_ok = 1;
    @(negedge clk);
    host_low = 1'b1;
    repeat (5) @(negedge clk);
    host_low = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    for (int s = 0; s < 16; s++) begin
      seen[s] = sirq_oe;
      @(negedge clk);
      if (sirq_oe) rel_ok = 0;
      @(negedge clk);
      if (sirq_oe) rel_ok = 0;
      @(negedge clk);
    end
  endtask

  task automatic watch_quiet(input int n, output bit any);
    any = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (sirq_oe) any = 1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  rd;
    logic [15:0] seen;
    bit          rel_ok;
    bit          any;
    logic [3:0]  pat;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(1'b0, rd); chk("R1 mask byte 0 after reset", rd, 8'h00);
    rd_reg(1'b1, rd); chk("R1 mask byte 1 after reset", rd, 8'h00);
    chk("R1 sirq_oe after reset", sirq_oe, 1'b0);

    // vector table: R6 R7 R8 plus R4 slot timing
    for (int v = 0; v < NVEC; v++) begin
      wr_reg(1'b0, VEC[v][10:3]);
      wr_reg(1'b1, {5'b0, VEC[v][2:0]});
      @(negedge clk);
      irq_in = VEC[v][21:11];
      repeat (4) @(negedge clk);
      run_frame(seen, rel_ok);
      chk($sformatf("R4 R7 R8 slot pattern vector %0d", v), seen,
          exp_mask(VEC[v][21:11], VEC[v][10:3], VEC[v][2:0]));
      chk($sformatf("R6 release in recovery/turnaround vector %0d", v), rel_ok, 1'b1);
      @(negedge clk);
      host_low = 1'b1;
      repeat (2) @(negedge clk);
      host_low = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R2 / R3 readback
    wr_reg(1'b0, 8'h5A);
    rd_reg(1'b0, rd); chk("R2 mask byte 0 readback", rd, 8'h5A);
    wr_reg(1'b1, 8'hFF);
    rd_reg(1'b1, rd); chk("R3 reserved bits read zero", rd, 8'h07);

    // everything enabled, all inputs low: any frame would drive the line
    wr_reg(1'b0, 8'h00);
    wr_reg(1'b1, 8'h00);
    irq_in = '0;
    repeat (4) @(negedge clk);

    // R5 short start pulse
    host_low = 1'b1;
    repeat (3) @(negedge clk);
    host_low = 1'b0;
    watch_quiet(60, any);
    chk("R5 three-clock pulse starts no frame", any, 1'b0);

    // R11 stop pulse after a frame
    run_frame(seen, rel_ok);
    chk("R7 all enabled low inputs", seen, 16'hDEF8);
    host_low = 1'b1;
    repeat (2) @(negedge clk);
    host_low = 1'b0;
    watch_quiet(60, any);
    chk("R11 stop pulse starts no frame", any, 1'b0);

    // R10 continuous mode: change on enabled input
    irq_in[2] = 1'b1;
    watch_quiet(10, any);
    chk("R10 no request in continuous mode", any, 1'b0);

    // R9 quiet mode request timing and width
    quiet_mode = 1'b1;
    repeat (4) @(negedge clk);
    irq_in[0] = 1'b1;
    pat = '0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pat[i] = sirq_oe;
    end
    chk("R9 one-clock request two clocks after registering", pat, 4'b0100);
    repeat (10) @(negedge clk);

    // R10 quiet mode, disabled input
    wr_reg(1'b0, 8'h02);
    repeat (4) @(negedge clk);
    irq_in[1] = 1'b1;
    watch_quiet(10, any);
    chk("R10 masked change gives no request", any, 1'b0);

    // R2 mapping: disabling IRQ4 (bit 1) hides only slot 4
    quiet_mode = 1'b0;
    irq_in = '0;
    repeat (4) @(negedge clk);
    run_frame(seen, rel_ok);
    chk("R2 bit 1 masks slot 4", seen, 16'hDEE8);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule